// File: doc/BRIEF.md
# Command-Block DMA Copy Engine

This is a single-channel copy engine that moves bytes between system memory and a byte-wide device port without processor help. The host does not program the transfer itself. It places a four-word command block in memory and writes that block's address to the engine. The engine then asks for the memory bus, reads the block, and runs the copy it describes. When the copy is finished, it raises an interrupt line.

The command block holds, at word offsets 0, 4, 8 and 12 from its (word-aligned) address, the source byte address, the destination byte address, a direction word and the byte count. Direction bit 0 set means memory-to-device: bytes are read starting at the source address and sent out the transmit port, and the destination word is unused. Direction bit 0 clear means device-to-memory: bytes taken from the receive port are written starting at the destination address, and the source word is unused. The memory port is one 32-bit word wide and always presents a word-aligned address. The engine makes one memory access per byte and picks the byte lane itself.

Top module: `cmdblk_dma`

## Requirements
- R1: A write with `host_sel`=0 while idle accepts `host_wdata` as the command-block address, and the engine then makes four word reads (`mem_be`=4'hF) at that address +0, +4, +8 and +12, in that order.
- R2: `bus_req` goes high after a start is accepted and stays high until the cycle of the last memory access of the job; it is low on the cycle after completion. `mem_valid` is never high unless `bus_gnt` is high.
- R3: In memory-to-device mode (direction bit 0 = 1), the bytes at source, source+1, … source+count−1 appear on `tx_data` in that order, one per `tx_valid`/`tx_ready` handshake, and `tx_data` holds steady while the transmit port stalls.
- R4: In device-to-memory mode (direction bit 0 = 0), byte i accepted on `rx_valid`/`rx_ready` is written at destination+i. The write uses `mem_we`=1, one `mem_be` bit set at the lane addr[1:0], and that byte placed in the selected lane of `mem_wdata`.
- R5: Byte lanes are little-endian: lane k is bits 8k+7..8k of the data word and matches address bits [1:0] = k. Every byte access drives the aligned word address `{addr[31:2],2'b00}`.
- R6: Only the low 16 bits of the count word are used. A count of zero ends the job right after the fourth command-block read, with no data access, and still raises `irq`.
- R7: `irq` sets when a job completes and stays set until the host writes `host_sel`=1 with `host_wdata` bit 0 set.
- R8: A start write while busy is ignored and leaves the running job unchanged, and it sets `err`. `err` stays set until the host writes `host_sel`=1 with `host_wdata` bit 1 set.
- R9: `busy` is high from the cycle after an accepted start until the job completes, and it is low after reset.
- R10: Source and destination addresses need not be aligned, and a transfer may cross word boundaries. The address advances by one for each byte moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = start (command-block address), 1 = flag clear |
| host_wdata | input | 32 | Host write data |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Completion interrupt, sticky |
| err | output | 1 | Start-while-busy error flag, sticky |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Device takes the byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Engine takes the byte |

## Verification
A corrupted address counter or a wrong lane choice shows up on the very next memory access, as a wrong `mem_addr` or `mem_be`. The bench therefore checks every access against a queue of expected accesses as the access completes. A wrong byte count or a direction bit latched wrongly shows up only at the end of the job: there are extra or missing accesses or bytes, and `irq` comes early or late. This is caught when the queues are not empty, or are overrun, at completion. A sequencer stuck in a non-idle state keeps `busy` and `bus_req` high, which the bench catches with a bounded wait for `irq`.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DESC_WORDS = 4;
    localparam logic HSEL_START = 1'b0;
    localparam logic HSEL_CLEAR = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RD,
        ST_TX,
        ST_RX,
        ST_WR
    } dma_st_e;
endpackage

// File: rtl/dma_lane.sv
module dma_lane #(
    parameter int DW = 32
) (
    input  logic [$clog2(DW/8)-1:0] addr_lo,
    input  logic                    word_acc,
    input  logic [7:0]              byte_in,
    input  logic [DW-1:0]           rdata,
    output logic [DW/8-1:0]         be,
    output logic [DW-1:0]           wdata,
    output logic [7:0]              rd_byte
);
    localparam int LANES = DW / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            be[k]             = word_acc || (addr_lo == k);
            wdata[8*k +: 8]   = byte_in;
        end
    end

    always_comb begin
        rd_byte = rdata[8*addr_lo +: 8];
    end
endmodule

// File: rtl/dma_status.sv
module dma_status #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          busy,
    input  logic          done,
    output logic          start,
    output logic          irq,
    output logic          err
);
    import dma_pkg::*;

    typedef struct packed {
        logic irq;
        logic err;
    } flags_t;

    flags_t q, d;
    logic   start_req, clr_irq, clr_err;

    always_comb begin
        start_req = wr_en && (wr_sel == HSEL_START);
        clr_irq   = wr_en && (wr_sel == HSEL_CLEAR) && wr_data[0];
        clr_err   = wr_en && (wr_sel == HSEL_CLEAR) && wr_data[1];
        start     = start_req && !busy;
        d         = q;
        d.irq     = (q.irq && !clr_irq) || done;
        d.err     = (q.err && !clr_err) || (start_req && busy);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq = q.irq;
    assign err = q.err;

    // R7
    irq_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);
    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_irq |=> irq);
    // R8
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && busy |=> err);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] blk_addr,
    output logic          busy,
    output logic          done,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          acc_valid,
    output logic          acc_we,
    output logic          acc_word,
    output logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] rdata,
    input  logic          ready,
    input  logic [7:0]    rd_byte,
    output logic [7:0]    wr_byte,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          rx_ready
);
    import dma_pkg::*;

    localparam int IW = $clog2(DESC_WORDS);
    localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);
    localparam int BPW = DW / 8;

    typedef struct packed {
        dma_st_e       st;
        logic [IW-1:0] idx;
        logic [AW-1:0] ptr;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          m2d;
        logic [7:0]    byt;
    } ctrl_t;

    ctrl_t q, d;
    logic  acc_done;

    always_comb begin
        d         = q;
        bus_req   = 1'b0;
        acc_valid = 1'b0;
        acc_we    = 1'b0;
        acc_word  = 1'b0;
        acc_addr  = '0;
        tx_valid  = 1'b0;
        rx_ready  = 1'b0;
        done      = 1'b0;
        acc_done  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.ptr = blk_addr;
                    d.idx = '0;
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                bus_req   = 1'b1;
                acc_word  = 1'b1;
                acc_addr  = q.ptr + AW'(q.idx) * AW'(BPW);
                acc_valid = bus_gnt;
                acc_done  = acc_valid && ready;
                if (acc_done) begin
                    d.idx = q.idx + 1'b1;
                    case (q.idx)
                        IW'(0):  d.src = rdata[AW-1:0];
                        IW'(1):  d.dst = rdata[AW-1:0];
                        IW'(2):  d.m2d = rdata[0];
                        default: d.cnt = rdata[CW-1:0];
                    endcase
                    if (q.idx == LAST_IDX) begin
                        if (rdata[CW-1:0] == '0) begin
                            d.st = ST_IDLE;
                            done = 1'b1;
                        end else begin
                            d.st = q.m2d ? ST_RD : ST_RX;
                        end
                    end
                end
            end
            ST_RD: begin
                bus_req   = 1'b1;
                acc_addr  = q.src;
                acc_valid = bus_gnt;
                acc_done  = acc_valid && ready;
                if (acc_done) begin
                    d.byt = rd_byte;
                    d.st  = ST_TX;
                end
            end
            ST_TX: begin
                bus_req  = (q.cnt != CW'(1));
                tx_valid = 1'b1;
                if (tx_ready) begin
                    d.src = q.src + 1'b1;
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == CW'(1)) begin
                        d.st = ST_IDLE;
                        done = 1'b1;
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
            ST_RX: begin
                bus_req  = 1'b1;
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.byt = rx_data;
                    d.st  = ST_WR;
                end
            end
            ST_WR: begin
                bus_req   = 1'b1;
                acc_addr  = q.dst;
                acc_we    = 1'b1;
                acc_valid = bus_gnt;
                acc_done  = acc_valid && ready;
                if (acc_done) begin
                    d.dst = q.dst + 1'b1;
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == CW'(1)) begin
                        d.st = ST_IDLE;
                        done = 1'b1;
                    end else begin
                        d.st = ST_RX;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign tx_data = q.byt;
    assign wr_byte = q.byt;

    // R2
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_req);
    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
    // R9
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/cmdblk_dma.sv
module cmdblk_dma #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic          host_sel,
    input  logic [AW-1:0] host_wdata,
    output logic          busy,
    output logic          irq,
    output logic          err,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          rx_ready
);
    localparam int LW = $clog2(DW / 8);

    logic          start, done, acc_word;
    logic [AW-1:0] acc_addr;
    logic [7:0]    rd_byte, wr_byte;

    dma_status #(.AW(AW)) status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_we),
        .wr_sel  (host_sel),
        .wr_data (host_wdata),
        .busy    (busy),
        .done    (done),
        .start   (start),
        .irq     (irq),
        .err     (err)
    );

    dma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .blk_addr  (host_wdata),
        .busy      (busy),
        .done      (done),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .acc_valid (mem_valid),
        .acc_we    (mem_we),
        .acc_word  (acc_word),
        .acc_addr  (acc_addr),
        .rdata     (mem_rdata),
        .ready     (mem_ready),
        .rd_byte   (rd_byte),
        .wr_byte   (wr_byte),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready)
    );

    dma_lane #(.DW(DW)) lane_i (
        .addr_lo (acc_addr[LW-1:0]),
        .word_acc(acc_word),
        .byte_in (wr_byte),
        .rdata   (mem_rdata),
        .be      (mem_be),
        .wdata   (mem_wdata),
        .rd_byte (rd_byte)
    );

    assign mem_addr = {acc_addr[AW-1:LW], {LW{1'b0}}};

    // R2
    gnt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> bus_req && bus_gnt);
    // R4
    single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> $countones(mem_be) == 1);
endmodule

// File: tb/cmdblk_dma_tb_top.sv
module cmdblk_dma_tb_top;
    typedef struct packed {
        logic [31:0] a;
        logic        we;
        logic [3:0]  be;
        logic [7:0]  d;
    } acc_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_we = 1'b0, host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        busy, irq, err, bus_req, bus_gnt = 1'b1;
    logic        mem_valid, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        tx_valid, tx_ready = 1'b1, rx_valid = 1'b0, rx_ready;
    logic [7:0]  tx_data, rx_data = '0;

    logic [7:0]  mem [0:255];
    logic        mem_ok = 1'b1, stall = 1'b0;
    logic [7:0]  lfsr = 8'h5A;
    acc_t        exp_acc[$];
    logic [7:0]  exp_tx[$];
    logic [7:0]  rx_src[$];
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    cmdblk_dma dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .busy(busy), .irq(irq), .err(err),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    always_comb begin
        mem_ready = mem_valid && mem_ok;
        mem_rdata = {mem[{mem_addr[7:2], 2'd3}], mem[{mem_addr[7:2], 2'd2}],
                     mem[{mem_addr[7:2], 2'd1}], mem[{mem_addr[7:2], 2'd0}]};
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: sample at negedge, act just after posedge
    always begin
        bit       rx_fire, wr_fire;
        acc_t     e, got;
        logic [7:0] t, wb;
        @(negedge clk);
        rx_fire = rx_valid && rx_ready;
        wr_fire = 1'b0;
        wb = '0;
        if (rst_n && mem_valid)
            chk(bus_gnt && bus_req, "R2 access without grant", {31'd0, bus_gnt}, 1);
        if (rst_n && mem_valid && mem_ready) begin
            got = '{a: mem_addr, we: mem_we, be: mem_be, d: 8'h00};
            if (mem_we)
                for (int k = 0; k < 4; k++) if (mem_be[k]) got.d = mem_wdata[8*k +: 8];
            if (exp_acc.size() == 0) begin
                chk(0, "R1/R6 unexpected memory access", got.a, 0);
            end else begin
                e = exp_acc.pop_front();
                if (!e.we) got.d = 8'h00;
                chk(got == e, "R1/R4/R5 memory access", got[44:13], e[44:13]);
                chk(got.be == e.be && got.d == e.d, "R4/R5 lanes and data",
                    {got.be, got.d}, {e.be, e.d});
            end
            if (mem_we) begin wr_fire = 1'b1; wb = got.d; end
        end
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) chk(0, "R3 unexpected tx byte", tx_data, 0);
            else begin
                t = exp_tx.pop_front();
                chk(tx_data == t, "R3 tx byte order", tx_data, t);
            end
        end
        @(posedge clk);
        if (wr_fire) mem[mem_addr[7:0] + {6'd0, $clog2(mem_be) == 0 ? 2'd0 :
            mem_be[1] ? 2'd1 : mem_be[2] ? 2'd2 : 2'd3}] = wb;
        #1;
        if (rx_fire) void'(rx_src.pop_front());
        lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_gnt = !stall || lfsr[0];
        mem_ok  = !stall || lfsr[1];
        tx_ready = !stall || lfsr[2];
        rx_valid = (rx_src.size() > 0) && (!stall || lfsr[3]);
        rx_data  = (rx_src.size() > 0) ? rx_src[0] : 8'h00;
    end

    task automatic host_write(input logic sel, input logic [31:0] data);
        @(posedge clk); #1;
        host_we = 1'b1; host_sel = sel; host_wdata = data;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    function automatic logic [7:0] rd8(input int a);
        return mem[a[7:0]];
    endfunction

    // driver: place command block and push expected items
    task automatic launch(input int blk, input int src, input int dst,
                          input bit m2d, input int cnt);
        logic [31:0] w [4];
        w[0] = src; w[1] = dst; w[2] = {31'd0, m2d}; w[3] = cnt;
        for (int i = 0; i < 4; i++) begin
            for (int b = 0; b < 4; b++) mem[8'(blk + 4*i + b)] = w[i][8*b +: 8];
            exp_acc.push_back('{a: blk + 4*i, we: 1'b0, be: 4'hF, d: 8'h00});
        end
        for (int i = 0; i < (cnt & 16'hFFFF); i++) begin
            int a;
            logic [7:0] v;
            a = m2d ? src + i : dst + i;
            if (m2d) begin
                exp_acc.push_back('{a: a & ~3, we: 1'b0, be: 4'(1 << (a & 3)), d: 8'h00});
                exp_tx.push_back(rd8(a));
            end else begin
                v = 8'(8'hA5 ^ (i * 13));
                rx_src.push_back(v);
                exp_acc.push_back('{a: a & ~3, we: 1'b1, be: 4'(1 << (a & 3)), d: v});
            end
        end
        host_write(1'b0, blk);
        @(negedge clk);
        chk(busy, "R9 busy after start", {31'd0, busy}, 1);
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        chk(irq, {req, " completion irq"}, {31'd0, irq}, 1);
        @(negedge clk);
        chk(!busy && !bus_req, {req, " R2/R9 idle after done"}, {busy, bus_req}, 0);
        chk(exp_acc.size() == 0 && exp_tx.size() == 0, {req, " queues drained"},
            exp_acc.size() + exp_tx.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !irq && !err && !bus_req && !mem_valid, "R9/R7/R8/R2 reset state",
            {busy, irq, err, bus_req, mem_valid}, 0);

        // R3 R5 R10: memory to device, unaligned, no stalls
        launch(8'hC0, 8'h41, 8'h00, 1'b1, 7);
        wait_done("R3");
        repeat (5) @(negedge clk);
        chk(irq, "R7 irq held", {31'd0, irq}, 1);
        host_write(1'b1, 32'h1);
        @(negedge clk);
        chk(!irq, "R7 irq cleared", {31'd0, irq}, 0);

        // R4 R10: device to memory with stalls
        stall = 1'b1;
        launch(8'hD0, 8'h00, 8'h82, 1'b0, 9);
        wait_done("R4");
        for (int i = 0; i < 9; i++)
            chk(mem[8'h82 + i] == 8'(8'hA5 ^ (i * 13)), "R4 memory contents",
                mem[8'h82 + i], 8'(8'hA5 ^ (i * 13)));
        host_write(1'b1, 32'h1);

        // R6: zero count (upper count bits ignored)
        launch(8'hE0, 8'h10, 8'h20, 1'b1, 32'h0001_0000);
        wait_done("R6");
        host_write(1'b1, 32'h1);

        // R8: start while busy
        launch(8'hF0, 8'h9D, 8'h00, 1'b1, 20);
        repeat (6) @(posedge clk);
        host_write(1'b0, 32'h0000_00E0);
        @(negedge clk);
        chk(err, "R8 err set", {31'd0, err}, 1);
        chk(busy, "R8 job continues", {31'd0, busy}, 1);
        wait_done("R8");
        host_write(1'b1, 32'h2);
        @(negedge clk);
        chk(!err && irq, "R8 err cleared irq kept", {err, irq}, 2'b01);
        host_write(1'b1, 32'h1);
        @(negedge clk);
        chk(!irq, "R7 irq cleared", {31'd0, irq}, 0);

        // R5: lanes, mem to device with stalls
        launch(8'hC0, 8'h9E, 8'h00, 1'b1, 5);
        wait_done("R5");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule